// File: doc/BRIEF.md
# Coil Driver Power-Mode Controller

This block sequences the three power modes of a voice-coil current driver: an off mode (OFF), a waiting mode (IDLE) in which the control registers can be written, and a driving mode (RUN) in which the output stage is on. The serial-clock level of the control bus, already synchronised to the system clock, acts as a sleep signal. A long low level sends the block to OFF, and a return to high wakes it into IDLE with a request to reload the register defaults. A nonzero coil-current setpoint starts the driver, and a zero setpoint stops it.

Five fault inputs come in from analog comparators: over-temperature, coil short, coil open, overcurrent and undervoltage. Each passes through a two-flop synchroniser and sets a sticky status flag. An over-temperature, short or open fault in RUN drops the block back to IDLE and asks the register file to clear the setpoint. Short and open are only believed when the setpoint is large enough for the comparators to be meaningful. The flags are wiped each time RUN is entered, and over-temperature keeps the block out of RUN while it lasts.

The surrounding register file acts on the single-cycle pulses this block issues: load defaults, clear setpoint and status clear.

Top module: `coil_pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is OFF (encoding OFF=0, IDLE=1, RUN=2), the output stage is disabled, all pulse outputs are low and all status flags are zero.
- R2: When `scl_lvl` is sampled low on IDLE_LIMIT consecutive clock edges, the block enters OFF from IDLE or RUN on the next edge. Any high sample restarts the count. The block stays in OFF while `scl_lvl` remains low.
- R3: In OFF, a high `scl_lvl` moves the block to IDLE, and `load_dflt` is high for exactly that one cycle.
- R4: In IDLE, a nonzero setpoint with no synchronised over-temperature moves the block to RUN. `stat_clr` pulses for one cycle, and all status flags read zero in the first RUN cycle.
- R5: In RUN, a zero setpoint returns the block to IDLE. `drv_en` is high exactly while the mode is RUN.
- R6: `sw_rst` in IDLE or RUN leaves the block in IDLE and pulses `load_dflt`. It takes priority over faults and the setpoint, but not over the R2 timeout.
- R7: A synchronised over-temperature, valid short or valid open fault in RUN moves the block to IDLE, pulses `sp_clr` for one cycle, and sets the matching flag.
- R8: Short and open faults are ignored unless the mode is RUN and the setpoint is at least DET_MIN (default 256). When ignored, they cause no mode change and no flag.
- R9: While the synchronised over-temperature is high, IDLE never moves to RUN. Its flag is set in any mode.
- R10: Overcurrent and undervoltage set their flags in any mode and never change the mode.
- R11: Each raw fault is seen through two flops, so its flag is set on the third clock edge after the input rises. Flag bit positions are: 0 overcurrent, 1 undervoltage, 2 open, 3 short, 4 over-temperature. Flags hold until the next RUN entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_lvl | input | 1 | Synchronised serial-clock level |
| setpoint | input | SP_W | Coil-current setpoint from the register file |
| sw_rst | input | 1 | Software-reset pulse |
| flt_ot | input | 1 | Raw over-temperature fault |
| flt_short | input | 1 | Raw coil-short fault |
| flt_open | input | 1 | Raw coil-open fault |
| flt_uv | input | 1 | Raw undervoltage fault |
| flt_ovc | input | 1 | Raw overcurrent fault |
| mode | output | 2 | Current mode (0 OFF, 1 IDLE, 2 RUN) |
| drv_en | output | 1 | Output-stage enable |
| load_dflt | output | 1 | One-cycle request to reload register defaults |
| sp_clr | output | 1 | One-cycle request to clear the setpoint |
| stat_clr | output | 1 | One-cycle pulse on RUN entry |
| status | output | 5 | Sticky fault flags |

## Verification
The bench builds the block with IDLE_LIMIT set to 16 instead of the default 25000. This makes the shutdown timeout, and the restart of the count by a single high sample, reachable in a few dozen cycles. SP_W and DET_MIN keep their defaults of 10 and 256. Setpoints of 100 and 300 therefore fall on both sides of the short/open qualification threshold. Faults are pulsed for one cycle and also held, so the synchroniser latency and the over-temperature block on RUN entry are both observed.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_RUN  = 2'd2
    } pmode_t;

    // bit 4 .. bit 0
    typedef struct packed {
        logic ot;
        logic shrt;
        logic open;
        logic uv;
        logic ovc;
    } flt_t;

    localparam int FLT_N = $bits(flt_t);

    function automatic logic halts_run(flt_t f, logic short_ok, logic open_ok);
        return f.ot | (f.shrt & short_ok) | (f.open & open_ok);
    endfunction

endpackage

// File: rtl/pm_fault_sync.sv
module pm_fault_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b0;
                synced[i] <= 1'b0;
            end else begin
                stage1[i] <= raw[i];
                synced[i] <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
    parameter int CNT_MAX = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    output logic expired
);
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LIM = CW'(CNT_MAX);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || scl_lvl)
            cnt_q <= '0;
        else if (cnt_q != LIM)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM);

    // R2
    cnt_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> !$past(scl_lvl));
endmodule

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pwrmode_pkg::*;
#(
    parameter int SP_W    = 10,
    parameter int DET_MIN = 256
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_lvl,
    input  logic [SP_W-1:0] setpoint,
    input  logic            sw_rst,
    input  logic            expired,
    input  flt_t            flt,
    output pmode_t          mode,
    output logic            load_dflt,
    output logic            sp_clr,
    output logic            stat_clr,
    output logic            enter_run,
    output logic            short_vld,
    output logic            open_vld
);
    localparam logic [SP_W-1:0] DET_V = SP_W'(DET_MIN);

    pmode_t st_q, st_n;
    logic   ld_n, clr_n, sp_nz, det_ok;

    assign sp_nz     = (setpoint != '0);
    assign det_ok    = (st_q == MODE_RUN) && (setpoint >= DET_V);
    assign short_vld = flt.shrt & det_ok;
    assign open_vld  = flt.open & det_ok;

    always_comb begin
        st_n      = st_q;
        ld_n      = 1'b0;
        clr_n     = 1'b0;
        enter_run = 1'b0;
        unique case (st_q)
            MODE_OFF: begin
                if (scl_lvl) begin
                    st_n = MODE_IDLE;
                    ld_n = 1'b1;
                end
            end
            MODE_IDLE: begin
                if (expired)
                    st_n = MODE_OFF;
                else if (sw_rst)
                    ld_n = 1'b1;
                else if (sp_nz && !flt.ot) begin
                    st_n      = MODE_RUN;
                    enter_run = 1'b1;
                end
            end
            MODE_RUN: begin
                if (expired)
                    st_n = MODE_OFF;
                else if (sw_rst) begin
                    st_n = MODE_IDLE;
                    ld_n = 1'b1;
                end else if (halts_run(flt, det_ok, det_ok)) begin
                    st_n  = MODE_IDLE;
                    clr_n = 1'b1;
                end else if (!sp_nz)
                    st_n = MODE_IDLE;
            end
            default: st_n = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= MODE_OFF;
            load_dflt <= 1'b0;
            sp_clr    <= 1'b0;
            stat_clr  <= 1'b0;
        end else begin
            st_q      <= st_n;
            load_dflt <= ld_n;
            sp_clr    <= clr_n;
            stat_clr  <= enter_run;
        end
    end

    assign mode = st_q;

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        load_dflt |=> !load_dflt);
    // R5
    zero_sp_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == MODE_RUN && !sp_nz && !expired) |=> (st_q == MODE_IDLE));
    // R9
    ot_block_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == MODE_IDLE && flt.ot) |=> (st_q != MODE_RUN));
    // R6
    swrst_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_rst && st_q != MODE_OFF && !expired) |=> (st_q == MODE_IDLE && load_dflt));
endmodule

// File: rtl/pm_status_flags.sv
module pm_status_flags
    import pwrmode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  flt_t flt,
    input  logic short_vld,
    input  logic open_vld,
    input  logic enter_run,
    output flt_t flags
);
    flt_t set_v;

    always_comb begin
        set_v      = flt;
        set_v.shrt = short_vld;
        set_v.open = open_vld;
    end

    always_ff @(posedge clk) begin
        if (rst || enter_run)
            flags <= '0;
        else
            flags <= flags | set_v;
    end

    // R4
    clear_on_run_chk: assert property (@(posedge clk) disable iff (rst)
        enter_run |=> (flags == '0));
    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!enter_run && flags.ovc) |=> flags.ovc);
endmodule

// File: rtl/coil_pwr_mode_ctrl.sv
module coil_pwr_mode_ctrl
    import pwrmode_pkg::*;
#(
    parameter int SP_W       = 10,
    parameter int DET_MIN    = 256,
    parameter int IDLE_LIMIT = 25000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_lvl,
    input  logic [SP_W-1:0] setpoint,
    input  logic            sw_rst,
    input  logic            flt_ot,
    input  logic            flt_short,
    input  logic            flt_open,
    input  logic            flt_uv,
    input  logic            flt_ovc,
    output logic [1:0]      mode,
    output logic            drv_en,
    output logic            load_dflt,
    output logic            sp_clr,
    output logic            stat_clr,
    output logic [4:0]      status
);
    flt_t   raw_f, sync_f, flags;
    pmode_t mode_e;
    logic   expired, enter_run, short_vld, open_vld;

    assign raw_f = '{ot: flt_ot, shrt: flt_short, open: flt_open, uv: flt_uv, ovc: flt_ovc};

    pm_fault_sync #(.W(FLT_N)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_f), .synced(sync_f)
    );

    pm_idle_timer #(.CNT_MAX(IDLE_LIMIT)) u_timer (
        .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .expired(expired)
    );

    pm_mode_fsm #(.SP_W(SP_W), .DET_MIN(DET_MIN)) u_fsm (
        .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .setpoint(setpoint),
        .sw_rst(sw_rst), .expired(expired), .flt(sync_f), .mode(mode_e),
        .load_dflt(load_dflt), .sp_clr(sp_clr), .stat_clr(stat_clr),
        .enter_run(enter_run), .short_vld(short_vld), .open_vld(open_vld)
    );

    pm_status_flags u_flags (
        .clk(clk), .rst(rst), .flt(sync_f), .short_vld(short_vld),
        .open_vld(open_vld), .enter_run(enter_run), .flags(flags)
    );

    assign mode   = mode_e;
    assign drv_en = (mode_e == MODE_RUN);
    assign status = flags;

    // R1
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({load_dflt, sp_clr, stat_clr}));
    // R8
    low_sp_no_det_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_RUN && setpoint < SP_W'(DET_MIN) && !sync_f.ot && !sw_rst && !expired && setpoint != '0)
        |=> (mode_e == MODE_RUN));
endmodule

// File: tb/tb_coil_pwr_mode_ctrl.sv
module tb_coil_pwr_mode_ctrl;
    localparam int T  = 16;
    localparam int DM = 256;

    logic clk = 0, rst = 1, scl = 0, swr = 0;
    logic [9:0] sp = 0;
    logic f_ot = 0, f_sh = 0, f_op = 0, f_uv = 0, f_oc = 0;
    logic [1:0] mode;
    logic drv_en, ld, clr, sc;
    logic [4:0] status;

    always #5 clk = ~clk;

    coil_pwr_mode_ctrl #(.SP_W(10), .DET_MIN(DM), .IDLE_LIMIT(T)) dut (
        .clk(clk), .rst(rst), .scl_lvl(scl), .setpoint(sp), .sw_rst(swr),
        .flt_ot(f_ot), .flt_short(f_sh), .flt_open(f_op), .flt_uv(f_uv),
        .flt_ovc(f_oc), .mode(mode), .drv_en(drv_en), .load_dflt(ld),
        .sp_clr(clr), .stat_clr(sc), .status(status)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    // reference model
    int m_st = 0, m_cnt = 0;
    logic [4:0] q1 = 0, q2 = 0, m_fl = 0;
    bit m_ld = 0, m_clr = 0, m_sc = 0;

    task automatic chk(string fld, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, fld, act, exp);
        end
    endtask

    task automatic model_step();
        bit expd, det, shv, opv, nrun;
        int nst;
        if (rst) begin
            m_st = 0; m_cnt = 0; q1 = 0; q2 = 0; m_fl = 0;
            m_ld = 0; m_clr = 0; m_sc = 0;
            return;
        end
        expd = (m_cnt == T);
        det  = (m_st == 2) && (sp >= DM);
        shv  = q2[3] && det;
        opv  = q2[2] && det;
        nst = m_st; m_ld = 0; m_clr = 0; nrun = 0;
        if (m_st == 0) begin
            if (scl) begin nst = 1; m_ld = 1; end
        end else if (expd) nst = 0;
        else if (swr) begin nst = 1; m_ld = 1; end
        else if (m_st == 1) begin
            if (sp != 0 && !q2[4]) begin nst = 2; nrun = 1; end
        end else begin
            if (q2[4] || shv || opv) begin nst = 1; m_clr = 1; end
            else if (sp == 0) nst = 1;
        end
        m_sc = nrun;
        if (nrun) m_fl = 0;
        else m_fl = m_fl | {q2[4], shv, opv, q2[1], q2[0]};
        if (scl) m_cnt = 0; else if (m_cnt < T) m_cnt++;
        q2 = q1;
        q1 = {f_ot, f_sh, f_op, f_uv, f_oc};
        m_st = nst;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk("mode", int'(mode), m_st);
        chk("drv_en", int'(drv_en), int'(m_st == 2));
        chk("load_dflt", int'(ld), int'(m_ld));
        chk("sp_clr", int'(clr), int'(m_clr));
        chk("stat_clr", int'(sc), int'(m_sc));
        chk("status", int'(status), int'(m_fl));
        if (m_ld || m_clr) sp = 0;   // register file reacts
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        @(negedge clk);
        tag = "R1"; run(3);
        rst = 0; run(3);
        tag = "R3"; scl = 1; run(3);
        tag = "R4"; sp = 100; run(4);
        tag = "R5"; sp = 0; run(3);
        tag = "R7"; sp = 300; run(3);
        f_sh = 1; tick(); f_sh = 0; run(5);
        tag = "R4"; sp = 300; run(3);
        tag = "R8"; sp = 100; run(2);
        f_op = 1; f_sh = 1; run(6); f_op = 0; f_sh = 0; run(3);
        tag = "R11"; f_oc = 1; tick(); f_oc = 0; run(4);
        tag = "R10"; f_uv = 1; run(3); f_uv = 0; run(2);
        tag = "R7"; sp = 400; run(2); f_op = 1; tick(); f_op = 0; run(4);
        tag = "R6"; sp = 500; run(3); swr = 1; f_ot = 1; tick(); swr = 0; f_ot = 0; run(4);
        tag = "R9"; f_ot = 1; run(3); sp = 50; run(6);
        f_ot = 0; run(5);
        tag = "R7"; f_ot = 1; tick(); f_ot = 0; run(5);
        tag = "R6"; swr = 1; tick(); swr = 0; run(2);
        tag = "R2"; sp = 80; run(3);
        scl = 0; run(10); scl = 1; tick(); scl = 0; run(10);
        scl = 1; run(2); scl = 0; run(T + 6);
        tag = "R3"; scl = 1; run(4);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule